// File: doc/BRIEF.md
# Precision-Time Packet Stamp Capture

This block records the value of a free-running 64-bit time counter at the moment a timing packet starts to cross the MAC. It runs two independent capture slots, one for transmit and one for receive. Each slot holds exactly one stamp. Once a slot has captured, it ignores every later packet until software reads the upper half of the stamp, and that read frees the slot again.

On the transmit side, a packet is stamped when the direction is enabled and the packet-start strobe arrives with the packet's stamp-request mark set. The receive side has to decide for itself whether a packet qualifies, using header fields that an upstream parser has already extracted:

- the Ethertype;
- a UDP flag and the UDP destination port;
- the protocol version;
- the message type.

A 2-bit filter mode and a 4-bit message-type selector decide which packets qualify. Each stamp is presented as a low and a high 32-bit word, together with a valid flag.

Top module: `ptp_stamp_capture`

## Requirements
- R1: With `tx_en`=1, `tx_mark`=1 and `tx_valid`=0, a `tx_sof` pulse sets `tx_valid` at the next clock edge. The stored stamp equals the `time_in` value present in the cycle of the strobe.
- R2: While a slot's valid flag is 1 and no release read occurs, the slot keeps its stamp unchanged and its valid flag set, whatever packets arrive.
- R3: A high-word read strobe (`tx_rd_hi` / `rx_rd_hi`) in a cycle where the slot is valid clears the valid flag at the next edge. No capture happens in that cycle, even if a qualifying strobe is present. A read strobe while the slot is not valid has no effect.
- R4: `*_stamp_lo` carries bits 31:0 of the stored stamp and `*_stamp_hi` carries bits 63:32.
- R5: No capture occurs when the direction's enable is 0. No transmit capture occurs when `tx_mark` is 0.
- R6: Filter mode 0 (version 1 over UDP): a receive packet qualifies only when all of the following hold:
  - `rx_is_udp`=1;
  - `rx_dport`=319;
  - `rx_ver`=1;
  - `rx_mtype` equals `rx_msg_sel`.

  The Ethertype alone does not qualify the packet.
- R7: Filter mode 1 (version 2, one message type): a packet qualifies when all of the following hold:
  - either the Ethertype is 0x88F7, or the packet is UDP to port 319;
  - `rx_ver`=2;
  - `rx_mtype` equals `rx_msg_sel`.
- R8: Filter mode 2 (version 2 events): a packet qualifies with the same transport and version rule as R7, but for any `rx_mtype` from 0 to 3. `rx_msg_sel` is ignored in this mode.
- R9: Filter mode 3 is reserved and no receive packet qualifies in it.
- R10: After reset, both valid flags are 0 and all stamp words are 0.
- R11: The transmit and receive slots capture and release independently, including in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| time_in | input | 64 | Current time value |
| tx_en | input | 1 | Transmit capture enable |
| tx_sof | input | 1 | Transmit packet-start strobe |
| tx_mark | input | 1 | Transmit packet requests a stamp |
| tx_rd_hi | input | 1 | Read of transmit high word, releases slot |
| tx_valid | output | 1 | Transmit stamp held |
| tx_stamp_lo | output | 32 | Transmit stamp bits 31:0 |
| tx_stamp_hi | output | 32 | Transmit stamp bits 63:32 |
| rx_en | input | 1 | Receive capture enable |
| rx_mode | input | 2 | Receive filter mode (0..3, see R6-R9 text) |
| rx_msg_sel | input | 4 | Selected message type |
| rx_sof | input | 1 | Receive packet-start strobe |
| rx_etype | input | 16 | Parsed Ethertype |
| rx_is_udp | input | 1 | Packet is UDP |
| rx_dport | input | 16 | UDP destination port |
| rx_ver | input | 4 | Protocol version field |
| rx_mtype | input | 4 | Message type field |
| rx_rd_hi | input | 1 | Read of receive high word, releases slot |
| rx_valid | output | 1 | Receive stamp held |
| rx_stamp_lo | output | 32 | Receive stamp bits 31:0 |
| rx_stamp_hi | output | 32 | Receive stamp bits 63:32 |

## Verification
The assertions check on every cycle that a slot captures the time of its strobe cycle, that a held stamp stays frozen until a release, that a release empties the slot, and that an idle slot without a capture stays empty. The bench's scenarios, compared against a behavioural model, are the only way to show:

- the receive qualification per filter mode, including wrong ports, versions and types, and the reserved mode;
- the interplay of a release with a simultaneous strobe;
- the independence of the two directions.

// File: rtl/ptp_cap_pkg.sv
package ptp_cap_pkg;

    localparam int TIME_W  = 64;
    localparam int WORD_W  = TIME_W / 2;
    localparam int NUM_DIR = 2;
    localparam int DIR_TX  = 0;
    localparam int DIR_RX  = 1;

    localparam logic [15:0] TIMING_ETYPE  = 16'h88F7;
    localparam logic [15:0] TIMING_PORT   = 16'd319;
    localparam logic [3:0]  EVENT_MT_MAX  = 4'd3;
    localparam logic [3:0]  VER_ONE       = 4'd1;
    localparam logic [3:0]  VER_TWO       = 4'd2;

    typedef enum logic [1:0] {
        RXF_V1_UDP   = 2'd0,
        RXF_V2_ONE   = 2'd1,
        RXF_V2_EVENT = 2'd2,
        RXF_NONE     = 2'd3
    } rx_filt_e;

    typedef struct packed {
        logic [15:0] etype;
        logic        is_udp;
        logic [15:0] dport;
        logic [3:0]  ver;
        logic [3:0]  mtype;
    } rx_hdr_t;

    function automatic logic l4_hit(rx_hdr_t h);
        return h.is_udp && (h.dport == TIMING_PORT);
    endfunction

    function automatic logic l2_hit(rx_hdr_t h);
        return h.etype == TIMING_ETYPE;
    endfunction

endpackage

// File: rtl/ptp_rx_qualifier.sv
module ptp_rx_qualifier
    import ptp_cap_pkg::*;
(
    input  rx_filt_e   mode,
    input  logic [3:0] msg_sel,
    input  rx_hdr_t    hdr,
    output logic       hit
);
    logic transport_v2;

    always_comb begin
        transport_v2 = l2_hit(hdr) || l4_hit(hdr);
        unique case (mode)
            RXF_V1_UDP:   hit = l4_hit(hdr) && (hdr.ver == VER_ONE)
                                && (hdr.mtype == msg_sel);
            RXF_V2_ONE:   hit = transport_v2 && (hdr.ver == VER_TWO)
                                && (hdr.mtype == msg_sel);
            RXF_V2_EVENT: hit = transport_v2 && (hdr.ver == VER_TWO)
                                && (hdr.mtype <= EVENT_MT_MAX);
            default:      hit = 1'b0;
        endcase
    end

    // R9: reserved mode never qualifies; R6: mode 0 never qualifies without UDP port
    always_comb begin
        p_reserved_mode_r9: assert (!(mode == RXF_NONE && hit));
        p_v1_needs_port_r6: assert (!(mode == RXF_V1_UDP && hit && !l4_hit(hdr)));
    end

endmodule

// File: rtl/ptp_stamp_latch.sv
module ptp_stamp_latch
    import ptp_cap_pkg::*;
#(
    parameter int T_W = TIME_W,
    parameter int W_W = T_W / 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    input  logic               sof,
    input  logic               hit,
    input  logic               rd_hi,
    input  logic [T_W-1:0]     time_in,
    output logic               valid,
    output logic [W_W-1:0]     stamp_lo,
    output logic [T_W-W_W-1:0] stamp_hi
);
    logic [T_W-1:0] stamp_q;
    logic           take;
    logic           release_now;

    assign take        = en && sof && hit && !valid;
    assign release_now = valid && rd_hi;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid   <= 1'b0;
            stamp_q <= '0;
        end else if (release_now) begin
            valid   <= 1'b0;
        end else if (take) begin
            valid   <= 1'b1;
            stamp_q <= time_in;
        end
    end

    assign stamp_lo = stamp_q[W_W-1:0];
    assign stamp_hi = stamp_q[T_W-1:W_W];

    p_capture_time_r1: assert property (@(posedge clk) disable iff (rst)
        (!valid && en && sof && hit) |=> (valid && {stamp_hi, stamp_lo} == $past(time_in)));

    p_hold_locked_r2: assert property (@(posedge clk) disable iff (rst)
        (valid && !rd_hi) |=> (valid && $stable(stamp_lo) && $stable(stamp_hi)));

    p_release_r3: assert property (@(posedge clk) disable iff (rst)
        (valid && rd_hi) |=> !valid);

    p_idle_stays_r5: assert property (@(posedge clk) disable iff (rst)
        (!valid && !(en && sof && hit)) |=> !valid);

endmodule

// File: rtl/ptp_stamp_capture.sv
module ptp_stamp_capture
    import ptp_cap_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [63:0] time_in,
    input  logic        tx_en,
    input  logic        tx_sof,
    input  logic        tx_mark,
    input  logic        tx_rd_hi,
    output logic        tx_valid,
    output logic [31:0] tx_stamp_lo,
    output logic [31:0] tx_stamp_hi,
    input  logic        rx_en,
    input  logic [1:0]  rx_mode,
    input  logic [3:0]  rx_msg_sel,
    input  logic        rx_sof,
    input  logic [15:0] rx_etype,
    input  logic        rx_is_udp,
    input  logic [15:0] rx_dport,
    input  logic [3:0]  rx_ver,
    input  logic [3:0]  rx_mtype,
    input  logic        rx_rd_hi,
    output logic        rx_valid,
    output logic [31:0] rx_stamp_lo,
    output logic [31:0] rx_stamp_hi
);
    rx_hdr_t rx_hdr;
    logic    rx_hit;

    logic [NUM_DIR-1:0]        d_en, d_sof, d_hit, d_rd, d_valid;
    logic [WORD_W-1:0]         d_lo [NUM_DIR];
    logic [TIME_W-WORD_W-1:0]  d_hi [NUM_DIR];

    assign rx_hdr = '{etype: rx_etype, is_udp: rx_is_udp, dport: rx_dport,
                      ver: rx_ver, mtype: rx_mtype};

    ptp_rx_qualifier i_rx_qual (
        .mode    (rx_filt_e'(rx_mode)),
        .msg_sel (rx_msg_sel),
        .hdr     (rx_hdr),
        .hit     (rx_hit)
    );

    assign d_en[DIR_TX]  = tx_en;
    assign d_sof[DIR_TX] = tx_sof;
    assign d_hit[DIR_TX] = tx_mark;
    assign d_rd[DIR_TX]  = tx_rd_hi;
    assign d_en[DIR_RX]  = rx_en;
    assign d_sof[DIR_RX] = rx_sof;
    assign d_hit[DIR_RX] = rx_hit;
    assign d_rd[DIR_RX]  = rx_rd_hi;

    for (genvar g = 0; g < NUM_DIR; g++) begin : g_dir
        ptp_stamp_latch #(.T_W(TIME_W), .W_W(WORD_W)) i_latch (
            .clk      (clk),
            .rst      (rst),
            .en       (d_en[g]),
            .sof      (d_sof[g]),
            .hit      (d_hit[g]),
            .rd_hi    (d_rd[g]),
            .time_in  (time_in),
            .valid    (d_valid[g]),
            .stamp_lo (d_lo[g]),
            .stamp_hi (d_hi[g])
        );
    end

    assign tx_valid    = d_valid[DIR_TX];
    assign tx_stamp_lo = d_lo[DIR_TX];
    assign tx_stamp_hi = d_hi[DIR_TX];
    assign rx_valid    = d_valid[DIR_RX];
    assign rx_stamp_lo = d_lo[DIR_RX];
    assign rx_stamp_hi = d_hi[DIR_RX];

endmodule

// File: tb/test_ptp_stamp_capture.sv
module test_ptp_stamp_capture;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] time_in = '0;
    logic        tx_en = 0, tx_sof = 0, tx_mark = 0, tx_rd_hi = 0;
    logic        tx_valid;
    logic [31:0] tx_stamp_lo, tx_stamp_hi;
    logic        rx_en = 0, rx_sof = 0, rx_is_udp = 0, rx_rd_hi = 0;
    logic [1:0]  rx_mode = 0;
    logic [3:0]  rx_msg_sel = 0, rx_ver = 0, rx_mtype = 0;
    logic [15:0] rx_etype = 0, rx_dport = 0;
    logic        rx_valid;
    logic [31:0] rx_stamp_lo, rx_stamp_hi;

    int checks = 0;
    int failures = 0;
    int step_n = 0;
    bit         m_txv = 0, m_rxv = 0;
    logic [63:0] m_txs = '0, m_rxs = '0;

    always #10 clk = ~clk;

    ptp_stamp_capture i_ptp_stamp_capture (.*);

    function automatic bit ref_hit(int mode, int et, bit udp, int port,
                                   int ver, int mt, int sel);
        bit by_port = udp && (port == 319);
        bit by_type = (et == 'h88F7);
        if (mode == 0) return by_port && ver == 1 && mt == sel;
        if (mode == 1) return (by_type || by_port) && ver == 2 && mt == sel;
        if (mode == 2) return (by_type || by_port) && ver == 2 && mt <= 3;
        return 0;
    endfunction

    task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic compare(string tag);
        check(tag, "tx_valid", 64'(tx_valid), 64'(m_txv));
        check(tag, "tx_stamp", {tx_stamp_hi, tx_stamp_lo}, m_txs);
        check(tag, "rx_valid", 64'(rx_valid), 64'(m_rxv));
        check(tag, "rx_stamp", {rx_stamp_hi, rx_stamp_lo}, m_rxs);
    endtask

    // one clock: inputs already driven; model steps at the edge; compare after it
    task automatic tick(string tag);
        bit cap_tx, cap_rx;
        @(posedge clk);
        cap_tx = tx_en && tx_sof && tx_mark && !m_txv;
        cap_rx = rx_en && rx_sof && !m_rxv &&
                 ref_hit(rx_mode, rx_etype, rx_is_udp, rx_dport, rx_ver, rx_mtype, rx_msg_sel);
        if (rst) begin
            m_txv = 0; m_rxv = 0; m_txs = '0; m_rxs = '0;
        end else begin
            if (m_txv && tx_rd_hi) m_txv = 0;
            else if (cap_tx) begin m_txv = 1; m_txs = time_in; end
            if (m_rxv && rx_rd_hi) m_rxv = 0;
            else if (cap_rx) begin m_rxv = 1; m_rxs = time_in; end
        end
        #2;
        compare(tag);
        tx_sof = 0; rx_sof = 0; tx_rd_hi = 0; rx_rd_hi = 0;
        step_n++;
        time_in = 64'hA5C3_0000_1000_0000 + 64'(step_n) * 64'h1_0000_0013;
    endtask

    task automatic rx_pkt(int et, bit udp, int port, int ver, int mt);
        rx_sof = 1; rx_etype = 16'(et); rx_is_udp = udp; rx_dport = 16'(port);
        rx_ver = 4'(ver); rx_mtype = 4'(mt);
    endtask

    initial begin
        #(20 * 200000);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        tick("R10"); tick("R10");
        rst = 0;
        tick("R10");

        // R1/R4 transmit capture, R5 disabled or unmarked
        tx_sof = 1; tx_mark = 1; tick("R5 disabled");
        tx_en = 1; tx_sof = 1; tx_mark = 0; tick("R5 unmarked");
        tx_rd_hi = 1; tick("R3 read while empty");
        tx_mark = 1; tx_sof = 1; tick("R1 R4 tx capture");
        tick("R2 hold");
        tx_sof = 1; tick("R2 second packet ignored");
        tx_rd_hi = 1; tick("R3 release");
        tick("R3 empty after release");
        tx_sof = 1; tick("R1 recapture");
        tx_sof = 1; tx_rd_hi = 1; tick("R3 release beats strobe");
        tx_sof = 1; tick("R1 capture after release");
        tx_rd_hi = 1; tick("R3");

        // R6 mode 0
        rx_en = 1; rx_mode = 0; rx_msg_sel = 4'd1;
        rx_pkt('h88F7, 0, 0, 1, 1);   tick("R6 ethertype alone");
        rx_pkt('h0800, 1, 320, 1, 1); tick("R6 wrong port");
        rx_pkt('h0800, 1, 319, 2, 1); tick("R6 wrong version");
        rx_pkt('h0800, 1, 319, 1, 0); tick("R6 wrong type");
        rx_pkt('h0800, 1, 319, 1, 1); tick("R6 match");
        rx_pkt('h0800, 1, 319, 1, 1); tick("R2 rx locked");
        rx_rd_hi = 1; tick("R3 rx release");

        // R7 mode 1
        rx_mode = 1; rx_msg_sel = 4'd8;
        rx_pkt('h88F7, 0, 0, 2, 9);   tick("R7 wrong type");
        rx_pkt('h86DD, 0, 0, 2, 8);   tick("R7 other ethertype");
        rx_pkt('h88F7, 0, 0, 1, 8);   tick("R7 version 1");
        rx_pkt('h88F7, 0, 0, 2, 8);   tick("R7 ethertype match");
        rx_rd_hi = 1; tick("R3");
        rx_pkt('h0800, 1, 319, 2, 8); tick("R7 udp match");
        rx_rd_hi = 1; tick("R3");

        // R8 mode 2
        rx_mode = 2; rx_msg_sel = 4'd9;
        rx_pkt('h88F7, 0, 0, 2, 4);   tick("R8 type 4 rejected");
        rx_pkt('h88F7, 0, 0, 1, 0);   tick("R8 version 1 rejected");
        rx_pkt('h88F7, 0, 0, 2, 3);   tick("R8 type 3");
        rx_rd_hi = 1; tick("R3");
        rx_pkt('h0800, 1, 319, 2, 0); tick("R8 udp type 0");
        rx_rd_hi = 1; tick("R3");

        // R9 reserved mode
        rx_mode = 3; rx_msg_sel = 4'd0;
        rx_pkt('h88F7, 1, 319, 2, 0); tick("R9 reserved");
        rx_pkt('h0800, 1, 319, 1, 0); tick("R9 reserved");

        // R11 both directions
        rx_mode = 2; rx_en = 1;
        tx_sof = 1; rx_pkt('h88F7, 0, 0, 2, 1); tick("R11 both capture");
        tx_rd_hi = 1; tick("R11 tx release only");
        tx_sof = 1; rx_rd_hi = 1; tick("R11 tx capture rx release");
        rx_en = 0; rx_pkt('h88F7, 0, 0, 2, 1); tick("R5 rx disabled");
        tx_rd_hi = 1; tick("R11");

        rst = 1; tick("R10 reset clears");
        rst = 0; tick("R10");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule